// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank

This block is a bank of up to 32 general-purpose lines behind a 32-bit register port. Each register write carries byte enables, so byte, halfword and word writes are all accepted. The bank drives its lines from an output-data register, gated by a per-line direction bit. Lines set as inputs pass through a two-flop synchroniser. Each input line can then be watched for low level, high level, rising edge and falling edge, in any combination.

A detected event sets the line's bit in two separate status registers. Each status register has its own enable register and its own interrupt output, so two consumers can claim different subsets of lines. Level conditions keep re-asserting their status bit for as long as the line stays at that level. The enables, the wake-enable mask and the output data each have write-one-to-set and write-one-to-clear aliases. A configuration register selects an idle mode and a wake permission, and it can trigger a soft reset. When wake is permitted, a one-cycle wake pulse is produced for events on wake-enabled lines.

Top module: `gpio_bank_dual_irq`

## Requirements
- R1: After reset the registers read as follows. Offset 0x00 reads 0x25 when REV_ALT=1 and 0x18 otherwise. Offset 0x14 reads 1. Offset 0x34 (direction, 1 = input) reads all ones. Every other register reads 0, and pin_out, irq_a, irq_b and wake_o are 0.
- R2: A write to an ordinary register changes only the byte lanes whose bus_be bit is 1. The other lanes keep their old contents. The ordinary registers are 0x10, 0x1C, 0x20, 0x2C, 0x30, 0x34, 0x3C, 0x40, 0x44, 0x48, 0x4C, 0x50 and 0x54.
- R3: A write to a status, set or clear address treats the lanes whose bus_be bit is 0 as zero data.
- R4: Each 1 written to a clear address clears that bit, and each 1 written to a set address sets it. The clear/set pairs are 0x60/0x64 for enable A (0x1C), 0x70/0x74 for enable B (0x2C), 0x80/0x84 for wake enable (0x20) and 0x90/0x94 for output data (0x3C).
- R5: On a line whose direction bit is 1, an event sets the line's bit in both status A (0x18) and status B (0x28). The events are: low level with the 0x40 bit set, high level with the 0x44 bit set, a 0→1 change with the 0x48 bit set, and a 1→0 change with the 0x4C bit set. A line whose direction bit is 0 latches nothing, and an edge of the opposite sense latches nothing.
- R6: Writing 1 to a status bit clears it. Status bits that are not cleared stay set. A line that still meets an enabled level condition reads back as set right after the clear.
- R7: irq_a is 1 exactly when some bit is set in both status A and enable A. irq_b follows the same rule with status B and enable B.
- R8: Writes to 0x00, 0x14 and 0x38 have no effect.
- R9: The configuration register (0x10) keeps only bits 0, 2, 3 and 4. The control register (0x30) keeps 3 bits. The debounce enable register (0x50) keeps NLINES bits and the debounce time register (0x54) keeps 8 bits. Both debounce registers are stored only.
- R10: A configuration write whose merged bits [4:3] equal 3 is dropped completely, including any soft reset it requests.
- R11: An accepted configuration write with bit 1 set returns every register to its R1 value. The configuration register then takes the written value with bit 1 removed.
- R12: wake_o pulses for one cycle, one cycle after an event, when the event's line has its wake-enable bit set, configuration bit 2 is 1 and configuration bits [4:3] are nonzero. Otherwise wake_o stays 0.
- R13: pin_out equals the output data register ANDed with the inverse of the direction register.
- R14: Offset 0x38 returns the input pins through two flops. A pin change shows there after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Register byte offset |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NLINES | Line inputs |
| pin_out | output | NLINES | Line output values |
| irq_a | output | 1 | Interrupt from status/enable set A |
| irq_b | output | 1 | Interrupt from status/enable set B |
| wake_o | output | 1 | One-cycle wake request |

## Verification
The bench builds the bank with NLINES=16 and REV_ALT=1. The alternate revision value becomes observable, and the line registers span two byte lanes, so the lane-merge and lane-zeroing rules are tested on real data. The small width allows a full sweep: every line is run through all four detection kinds, with the opposite edge, the level re-latch after a clear, and the direction gate checked on each line.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam logic [7:0] A_REV      = 8'h00;
    localparam logic [7:0] A_SYSCFG   = 8'h10;
    localparam logic [7:0] A_SYSSTAT  = 8'h14;
    localparam logic [7:0] A_STA      = 8'h18;
    localparam logic [7:0] A_ENA      = 8'h1C;
    localparam logic [7:0] A_WKEN     = 8'h20;
    localparam logic [7:0] A_STB      = 8'h28;
    localparam logic [7:0] A_ENB      = 8'h2C;
    localparam logic [7:0] A_CTRL     = 8'h30;
    localparam logic [7:0] A_OE       = 8'h34;
    localparam logic [7:0] A_DIN      = 8'h38;
    localparam logic [7:0] A_DOUT     = 8'h3C;
    localparam logic [7:0] A_LO       = 8'h40;
    localparam logic [7:0] A_HI       = 8'h44;
    localparam logic [7:0] A_RISE     = 8'h48;
    localparam logic [7:0] A_FALL     = 8'h4C;
    localparam logic [7:0] A_DBEN     = 8'h50;
    localparam logic [7:0] A_DBTIME   = 8'h54;
    localparam logic [7:0] A_ENA_CLR  = 8'h60;
    localparam logic [7:0] A_ENA_SET  = 8'h64;
    localparam logic [7:0] A_ENB_CLR  = 8'h70;
    localparam logic [7:0] A_ENB_SET  = 8'h74;
    localparam logic [7:0] A_WK_CLR   = 8'h80;
    localparam logic [7:0] A_WK_SET   = 8'h84;
    localparam logic [7:0] A_DOUT_CLR = 8'h90;
    localparam logic [7:0] A_DOUT_SET = 8'h94;

    localparam logic [4:0] CFG_KEEP = 5'h1D;
    localparam logic [1:0] IDLE_BAD = 2'b11;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] eff_v,
                                               input logic [31:0] m);
        return (old_v & ~m) | eff_v;
    endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] oe_i,
    input  logic [W-1:0] lo_en_i,
    input  logic [W-1:0] hi_en_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    output logic [W-1:0] ev_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_line
        logic is_lo, is_hi, is_rise, is_fall;
        assign is_lo   = lo_en_i[g]   & ~lvl_i[g];
        assign is_hi   = hi_en_i[g]   &  lvl_i[g];
        assign is_rise = rise_en_i[g] &  lvl_i[g] & ~prev_q[g];
        assign is_fall = fall_en_i[g] & ~lvl_i[g] &  prev_q[g];
        assign ev_o[g] = oe_i[g] & (is_lo | is_hi | is_rise | is_fall);
    end
endmodule

// File: rtl/gpio_bank_dual_irq.sv
module gpio_bank_dual_irq
    import gpb_pkg::*;
#(
    parameter int NLINES  = 32,
    parameter bit REV_ALT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic              irq_a,
    output logic              irq_b,
    output logic              wake_o
);
    localparam logic [31:0] REV_VAL = REV_ALT ? 32'h25 : 32'h18;

    typedef logic [NLINES-1:0] vec_t;

    typedef struct packed {
        logic [4:0] cfg;
        logic [2:0] ctrl;
        logic [7:0] dbt;
        vec_t       sta;
        vec_t       stb;
        vec_t       ena;
        vec_t       enb;
        vec_t       wken;
        vec_t       oe;
        vec_t       dout;
        vec_t       lo;
        vec_t       hi;
        vec_t       rise;
        vec_t       fall;
        vec_t       dben;
        logic       wake;
    } regs_t;

    function automatic regs_t reset_regs();
        regs_t r;
        r    = '0;
        r.oe = '1;
        return r;
    endfunction

    regs_t       q, d;
    vec_t        lvl, ev, eff_n;
    logic [31:0] lm, eff;
    logic [4:0]  cfg_m;
    logic        cfg_wr, cfg_ok, soft_rst;

    gpb_sync #(.W(NLINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (lvl)
    );

    gpb_detect #(.W(NLINES)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl),
        .oe_i      (q.oe),
        .lo_en_i   (q.lo),
        .hi_en_i   (q.hi),
        .rise_en_i (q.rise),
        .fall_en_i (q.fall),
        .ev_o      (ev)
    );

    always_comb begin
        lm       = lane_mask(bus_be);
        eff      = bus_wdata & lm;
        eff_n    = vec_t'(eff);
        cfg_m    = 5'(lane_merge(32'(q.cfg), eff, lm));
        cfg_wr   = bus_we && (bus_addr == A_SYSCFG);
        cfg_ok   = cfg_wr && (cfg_m[4:3] != IDLE_BAD);
        soft_rst = cfg_ok && cfg_m[1];
    end

    always_comb begin
        d      = q;
        d.sta  = q.sta | ev;
        d.stb  = q.stb | ev;
        d.wake = (|(ev & q.wken)) && q.cfg[2] && (q.cfg[4:3] != 2'b00);
        if (bus_we) begin
            case (bus_addr)
                A_STA:      d.sta  = (q.sta & ~eff_n) | ev;
                A_STB:      d.stb  = (q.stb & ~eff_n) | ev;
                A_ENA:      d.ena  = vec_t'(lane_merge(32'(q.ena),  eff, lm));
                A_ENB:      d.enb  = vec_t'(lane_merge(32'(q.enb),  eff, lm));
                A_WKEN:     d.wken = vec_t'(lane_merge(32'(q.wken), eff, lm));
                A_OE:       d.oe   = vec_t'(lane_merge(32'(q.oe),   eff, lm));
                A_DOUT:     d.dout = vec_t'(lane_merge(32'(q.dout), eff, lm));
                A_LO:       d.lo   = vec_t'(lane_merge(32'(q.lo),   eff, lm));
                A_HI:       d.hi   = vec_t'(lane_merge(32'(q.hi),   eff, lm));
                A_RISE:     d.rise = vec_t'(lane_merge(32'(q.rise), eff, lm));
                A_FALL:     d.fall = vec_t'(lane_merge(32'(q.fall), eff, lm));
                A_DBEN:     d.dben = vec_t'(lane_merge(32'(q.dben), eff, lm));
                A_CTRL:     d.ctrl = 3'(lane_merge(32'(q.ctrl), eff, lm));
                A_DBTIME:   d.dbt  = 8'(lane_merge(32'(q.dbt),  eff, lm));
                A_ENA_CLR:  d.ena  = q.ena  & ~eff_n;
                A_ENA_SET:  d.ena  = q.ena  |  eff_n;
                A_ENB_CLR:  d.enb  = q.enb  & ~eff_n;
                A_ENB_SET:  d.enb  = q.enb  |  eff_n;
                A_WK_CLR:   d.wken = q.wken & ~eff_n;
                A_WK_SET:   d.wken = q.wken |  eff_n;
                A_DOUT_CLR: d.dout = q.dout & ~eff_n;
                A_DOUT_SET: d.dout = q.dout |  eff_n;
                default:    ;
            endcase
        end
        if (cfg_ok) begin
            if (soft_rst) d = reset_regs();
            d.cfg = cfg_m & CFG_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_regs();
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            A_REV:                        bus_rdata = REV_VAL;
            A_SYSCFG:                     bus_rdata = 32'(q.cfg);
            A_SYSSTAT:                    bus_rdata = 32'd1;
            A_STA:                        bus_rdata = 32'(q.sta);
            A_STB:                        bus_rdata = 32'(q.stb);
            A_ENA, A_ENA_CLR, A_ENA_SET:  bus_rdata = 32'(q.ena);
            A_ENB, A_ENB_CLR, A_ENB_SET:  bus_rdata = 32'(q.enb);
            A_WKEN, A_WK_CLR, A_WK_SET:   bus_rdata = 32'(q.wken);
            A_CTRL:                       bus_rdata = 32'(q.ctrl);
            A_OE:                         bus_rdata = 32'(q.oe);
            A_DIN:                        bus_rdata = 32'(lvl);
            A_DOUT, A_DOUT_CLR, A_DOUT_SET: bus_rdata = 32'(q.dout);
            A_LO:                         bus_rdata = 32'(q.lo);
            A_HI:                         bus_rdata = 32'(q.hi);
            A_RISE:                       bus_rdata = 32'(q.rise);
            A_FALL:                       bus_rdata = 32'(q.fall);
            A_DBEN:                       bus_rdata = 32'(q.dben);
            A_DBTIME:                     bus_rdata = 32'(q.dbt);
            default:                      bus_rdata = 32'd0;
        endcase
    end

    assign pin_out = q.dout & ~q.oe;
    assign irq_a   = |(q.sta & q.ena);
    assign irq_b   = |(q.stb & q.enb);
    assign wake_o  = q.wake;

    // R6
    sta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_we && bus_addr == A_STA) && !soft_rst) |=> ((q.sta & $past(q.sta)) == $past(q.sta)));

    // R5
    ev_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev != '0) && !soft_rst) |=> ((q.sta & $past(ev)) == $past(ev)));

    // R5
    ev_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev != '0) && !soft_rst) |=> ((q.stb & $past(ev)) == $past(ev)));

    // R10
    idle_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_ok) |=> $stable(q.cfg));

    // R12
    wake_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(q.cfg[2]) && ($past(q.cfg[4:3]) != 2'b00)));

    // R4
    ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ENA_SET) |=> ((q.ena & $past(eff_n)) == $past(eff_n)));
endmodule

// File: tb/test_gpio_bank_dual_irq.sv
`timescale 1ns/1ps
module test_gpio_bank_dual_irq;
    localparam int N = 16;
    localparam logic [31:0] ALL = 32'h0000_FFFF;

    localparam logic [7:0] R_REV = 8'h00, R_CFG = 8'h10, R_SST = 8'h14, R_STA = 8'h18;
    localparam logic [7:0] R_ENA = 8'h1C, R_WK = 8'h20, R_STB = 8'h28, R_ENB = 8'h2C;
    localparam logic [7:0] R_CTL = 8'h30, R_OE = 8'h34, R_DIN = 8'h38, R_DOUT = 8'h3C;
    localparam logic [7:0] R_DBE = 8'h50, R_DBT = 8'h54;
    localparam logic [7:0] R_ENA_C = 8'h60, R_ENA_S = 8'h64, R_ENB_C = 8'h70, R_ENB_S = 8'h74;
    localparam logic [7:0] R_WK_C = 8'h80, R_WK_S = 8'h84, R_DO_C = 8'h90, R_DO_S = 8'h94;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [3:0]    bus_be = 4'h0;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic          irq_a, irq_b, wake_o;

    int nchk = 0;
    int nfail = 0;
    int wake_cnt = 0;

    always #4 clk = ~clk;

    gpio_bank_dual_irq #(.NLINES(N), .REV_ALT(1'b1)) i_gpio_bank_dual_irq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .irq_a(irq_a), .irq_b(irq_b),
        .wake_o(wake_o)
    );

    always @(negedge clk) if (wake_o) wake_cnt++;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v, input logic [3:0] be);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v; bus_be = be;
        @(negedge clk);
        bus_we = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_status();
        wr(R_STA, ALL, 4'hF);
        wr(R_STB, ALL, 4'hF);
    endtask

    // kind: 0 low level (0x40), 1 high level (0x44), 2 rise (0x48), 3 fall (0x4C)
    task automatic run_case(input int ln, input int kind);
        logic [31:0] bit_v;
        logic        start;
        bit_v = 32'h1 << ln;
        start = (kind == 0 || kind == 3);
        for (int k = 0; k < 4; k++) wr(8'h40 + 8'(4*k), 32'h0, 4'hF);
        pin_in = '0;
        pin_in[ln] = start;
        idle(4);
        clr_status();
        wr(8'h40 + 8'(4*kind), bit_v, 4'hF);
        idle(3);
        rchk("R5 idle state latches nothing", R_STA, 32'h0);
        pin_in[ln] = ~start;
        idle(4);
        rchk("R5 event status A", R_STA, bit_v);
        rchk("R5 event status B", R_STB, bit_v);
        clr_status();
        if (kind < 2) begin
            rchk("R6 level re-latch after clear", R_STA, bit_v);
            pin_in[ln] = start;
            idle(4);
            clr_status();
            rchk("R6 cleared once level gone", R_STA, 32'h0);
        end else begin
            pin_in[ln] = start;
            idle(4);
            rchk("R5 opposite edge ignored", R_STA, 32'h0);
        end
    endtask

    task automatic oe_case(input int ln);
        logic [31:0] bit_v;
        bit_v = 32'h1 << ln;
        pin_in = '0;
        wr(8'h48, bit_v, 4'hF);
        wr(R_OE, ALL & ~bit_v, 4'hF);
        idle(4);
        clr_status();
        pin_in[ln] = 1'b1;
        idle(4);
        rchk("R5 output line latches nothing", R_STA, 32'h0);
        wr(R_OE, ALL, 4'hF);
        wr(8'h48, 32'h0, 4'hF);
        pin_in = '0;
        idle(3);
    endtask

    task automatic wake_try(input logic [31:0] cfg, input logic wk, input int exp, input string req);
        int w0;
        wr(R_CFG, cfg, 4'hF);
        wr(8'h48, 32'h1, 4'hF);
        if (wk) wr(R_WK_S, 32'h1, 4'hF);
        else    wr(R_WK_C, 32'h1, 4'hF);
        pin_in = '0;
        idle(4);
        w0 = wake_cnt;
        pin_in[0] = 1'b1;
        idle(5);
        chk(req, 32'(wake_cnt - w0), 32'(exp));
        pin_in = '0;
        idle(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rchk("R1 revision", R_REV, 32'h25);
        rchk("R1 reset done", R_SST, 32'h1);
        rchk("R1 direction", R_OE, ALL);
        rchk("R1 config", R_CFG, 32'h0);
        rchk("R1 status A", R_STA, 32'h0);
        rchk("R1 enable B", R_ENB, 32'h0);
        chk("R1 pins", 32'(pin_out), 32'h0);
        chk("R1 irqs", {30'h0, irq_a, irq_b}, 32'h0);

        // R8 read-only offsets
        wr(R_REV, 32'hFFFF_FFFF, 4'hF);
        wr(R_SST, 32'hFFFF_FFFF, 4'hF);
        wr(R_DIN, 32'hFFFF_FFFF, 4'hF);
        rchk("R8 revision", R_REV, 32'h25);
        rchk("R8 reset done", R_SST, 32'h1);
        rchk("R8 data in", R_DIN, 32'h0);

        // R9 kept bits
        wr(R_CFG, 32'hFFFF_FFE5, 4'hF);
        rchk("R9 config mask", R_CFG, 32'h05);
        wr(R_CTL, 32'hFFFF_FFFF, 4'hF);
        rchk("R9 control width", R_CTL, 32'h7);
        wr(R_DBE, 32'hFFFF_FFFF, 4'hF);
        rchk("R9 debounce enable", R_DBE, ALL);
        wr(R_DBT, 32'h0000_1234, 4'hF);
        rchk("R9 debounce time", R_DBT, 32'h34);

        // R10 illegal idle mode, also with soft reset bit
        wr(R_ENA, 32'h00F0, 4'hF);
        wr(R_CFG, 32'h18, 4'hF);
        rchk("R10 config kept", R_CFG, 32'h05);
        wr(R_CFG, 32'h1A, 4'hF);
        rchk("R10 config kept with reset bit", R_CFG, 32'h05);
        rchk("R10 no soft reset", R_ENA, 32'h00F0);

        // R11 soft reset
        wr(R_OE, 32'h0, 4'hF);
        wr(R_CFG, 32'h0A, 4'hF);
        rchk("R11 config after soft reset", R_CFG, 32'h08);
        rchk("R11 enable cleared", R_ENA, 32'h0);
        rchk("R11 direction restored", R_OE, ALL);
        rchk("R11 control cleared", R_CTL, 32'h0);
        rchk("R11 debounce time cleared", R_DBT, 32'h0);

        // R2 lane merge
        wr(R_ENA, 32'h1234, 4'hF);
        wr(R_ENA, 32'hFFFF_AB00, 4'b0010);
        rchk("R2 upper lane only", R_ENA, 32'hAB34);
        wr(R_ENA, 32'h0000_00CD, 4'b0001);
        rchk("R2 lower lane only", R_ENA, 32'hABCD);
        wr(R_CFG, 32'hFFFF_FF04, 4'b0001);
        rchk("R2 config lane", R_CFG, 32'h04);

        // R4 set and clear aliases
        wr(R_ENA_S, 32'h0010, 4'hF);
        rchk("R4 enable A set", R_ENA, 32'hABDD);
        wr(R_ENA_C, 32'h0300, 4'hF);
        rchk("R4 enable A clear", R_ENA, 32'hA8DD);
        wr(R_ENB_S, 32'h8001, 4'hF);
        rchk("R4 enable B set", R_ENB, 32'h8001);
        wr(R_ENB_C, 32'h0001, 4'hF);
        rchk("R4 enable B clear", R_ENB, 32'h8000);
        wr(R_WK_S, 32'h0F00, 4'hF);
        rchk("R4 wake set", R_WK, 32'h0F00);
        wr(R_WK_C, 32'h0300, 4'hF);
        rchk("R4 wake clear", R_WK, 32'h0C00);
        wr(R_DOUT, 32'h5555, 4'hF);
        wr(R_DO_S, 32'h000A, 4'hF);
        rchk("R4 data out set", R_DOUT, 32'h555F);
        wr(R_DO_C, 32'h5000, 4'hF);
        rchk("R4 data out clear", R_DOUT, 32'h055F);

        // R3 unwritten lanes are zero for aliases
        wr(R_ENA_C, ALL, 4'b0001);
        rchk("R3 clear alias lower lane", R_ENA, 32'hA800);
        wr(R_DO_S, ALL, 4'b0010);
        rchk("R3 set alias upper lane", R_DOUT, 32'hFF5F);

        // R13 output gating
        wr(R_DOUT, ALL, 4'hF);
        wr(R_OE, 32'h0F0F, 4'hF);
        idle(1);
        chk("R13 pin out", 32'(pin_out), 32'hF0F0);
        wr(R_OE, ALL, 4'hF);
        idle(1);
        chk("R13 all inputs", 32'(pin_out), 32'h0);
        wr(R_ENA, 32'h0, 4'hF);
        wr(R_ENB, 32'h0, 4'hF);
        wr(R_WK, 32'h0, 4'hF);
        wr(R_CFG, 32'h0, 4'hF);

        // R14 synchroniser latency
        @(negedge clk);
        pin_in = 16'hA5C3;
        rchk("R14 no edge yet", R_DIN, 32'h0);
        @(negedge clk);
        rchk("R14 after one edge", R_DIN, 32'h0);
        @(negedge clk);
        rchk("R14 after two edges", R_DIN, 32'hA5C3);
        pin_in = '0;
        idle(3);

        // R5 R6 full sweep of lines and detection kinds
        for (int ln = 0; ln < N; ln++) begin
            for (int kind = 0; kind < 4; kind++) run_case(ln, kind);
            oe_case(ln);
        end

        // R7 interrupt outputs
        wr(8'h44, 32'h0008, 4'hF);
        pin_in = 16'h0008;
        idle(4);
        chk("R7 no enables", {30'h0, irq_a, irq_b}, 32'h0);
        wr(R_ENA_S, 32'h0008, 4'hF);
        idle(1);
        chk("R7 irq A only", {30'h0, irq_a, irq_b}, 32'h2);
        wr(R_ENB_S, 32'h0008, 4'hF);
        idle(1);
        chk("R7 both irqs", {30'h0, irq_a, irq_b}, 32'h3);
        wr(R_ENA_C, 32'h0008, 4'hF);
        idle(1);
        chk("R7 irq B only", {30'h0, irq_a, irq_b}, 32'h1);
        wr(R_ENA_S, 32'h0004, 4'hF);
        idle(1);
        chk("R7 enable on idle line", {30'h0, irq_a, irq_b}, 32'h1);
        wr(8'h44, 32'h0, 4'hF);
        clr_status();
        idle(1);
        chk("R7 status cleared", {30'h0, irq_a, irq_b}, 32'h0);
        pin_in = '0;
        wr(R_ENA, 32'h0, 4'hF);
        wr(R_ENB, 32'h0, 4'hF);
        idle(3);

        // R12 wake permission
        wake_try(32'h0C, 1'b1, 1, "R12 wake allowed");
        wake_try(32'h0C, 1'b0, 0, "R12 line not wake enabled");
        wake_try(32'h04, 1'b1, 0, "R12 idle mode zero");
        wake_try(32'h08, 1'b1, 0, "R12 wake bit clear");
        wake_try(32'h14, 1'b1, 1, "R12 other idle mode");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule